// File: doc/BRIEF.md
# Framed Serial Control-Register Write Port

This block is the receiving side of a 16-bit serial write port. A host signal processor uses it to load a small bank of control registers. The block runs from a master clock and divides it by two to make a bit clock, which it drives out to the host. The host presents a frame-start pulse and one data bit per bit-clock period. The block captures both on each rising edge of the bit clock it generates.

Each word is split into three fields: a 10-bit value, a 4-bit register address and a 2-bit select code. When the last bit has arrived, the value is written into the addressed register in one master-clock cycle, and a one-cycle write strobe marks the write. Address and select combinations that name no register are dropped. The registers appear as outputs. Four fixed bits of the register space are also brought out separately as section power enables.

The sampled frame pulse is echoed back as a frame output. A mode input controls this echo. When mode is high, the echo is driven. When mode is low, the pad enable is released and frame starts are ignored.

Top module: `ctl_serial_port`

## Requirements
- R1: `bit_clk` is low during reset and toggles on every master clock edge after reset, so one bit period is two master cycles.
- R2: `frame_in` and `data_in` are captured on the master edge that drives `bit_clk` high. A captured frame of 1 marks that same capture as the first bit of a word.
- R3: Bits arrive first to last as value[9:0] (MSB first), then address[3:0] (MSB first), then select[1:0]. As a 16-bit word this is {value, address, select}, with the first bit in word bit 15.
- R4: Select 2'b00 with address 0 to NUM_REGS-1 writes the value into that register. The register changes and `wr_stb` goes high for exactly one master cycle, one master cycle after the 16th capture.
- R5: Any other address or select combination changes no register and raises no strobe.
- R6: A frame captured before the 16th bit of a word discards the partial word and starts a new word at that capture.
- R7: Bits captured after a complete word without a new frame are ignored. They cause no write and no strobe.
- R8: With `mode_in` high, `frame_oe` is 1 and `frame_out` equals the most recently captured `frame_in`, updated at the same edge as the capture. With `mode_in` low, `frame_oe` is 0, `frame_out` is 0 and frame starts are ignored.
- R9: Control bit n of the register space is bit n mod 10 of register n div 10. `sect_en[k]` is control bit 14+k, which is register 1 bit 4+k. A value of 1 means the section is active.
- R10: A synchronous active-high `rst` clears every register, `sect_en`, `wr_stb`, `frame_out` and the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_in | input | 1 | High: echo enabled and frames accepted |
| frame_in | input | 1 | Frame-start pulse from the host |
| data_in | input | 1 | Serial data from the host |
| bit_clk | output | 1 | Generated bit clock, half the master rate |
| frame_out | output | 1 | Echo of the captured frame pulse |
| frame_oe | output | 1 | Output enable for the frame echo pad |
| wr_stb | output | 1 | One-cycle pulse on each accepted write |
| regs_flat | output | NUM_REGS*10 | Register bank; register i is bits [10i+9:10i] |
| sect_en | output | 4 | Section power enables, control bits 14 to 17 |

## Verification
The assertions check on every cycle that the bit clock alternates and that a strobe lasts one cycle and lands on a low bit-clock phase. They also check that the registers move only together with a strobe, that the echo changes only at capture edges, and that reset leaves a clean state. The field order, the register decode, the dropping of unused combinations, the abort on an early frame, the ignored trailing bits and the mode gating can only be shown by the bench's scenarios. These involve whole 16-bit words compared against a reference model, so a single-cycle property cannot cover them.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

    localparam int VAL_W   = 10;
    localparam int ADR_W   = 4;
    localparam int SEL_W   = 2;
    localparam int WORD_W  = VAL_W + ADR_W + SEL_W;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam logic [SEL_W-1:0] SEL_BANK = '0;

    typedef struct packed {
        logic [VAL_W-1:0] value;
        logic [ADR_W-1:0] addr;
        logic [SEL_W-1:0] sel;
    } ctl_word_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    function automatic logic word_hits(input ctl_word_t w, input int n_regs);
        return (w.sel == SEL_BANK) && (int'(w.addr) < n_regs);
    endfunction

endpackage

// File: rtl/ctl_bitclk.sv
module ctl_bitclk (
    input  logic clk,
    input  logic rst,
    output logic bit_clk,
    output logic smp_en
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    // the edge that lifts the bit clock is the capture edge
    assign smp_en  = ~phase_q & ~rst;
    assign bit_clk = phase_q;
endmodule

// File: rtl/ctl_deframer.sv
module ctl_deframer
    import ctl_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_en,
    input  logic      start_ok,
    input  logic      din,
    output logic      word_vld,
    output ctl_word_t word
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_t         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (smp_en) begin
                if (start_ok) begin
                    sh_q  <= {sh_q[WORD_W-2:0], din};
                    cnt_q <= CNT_W'(1);
                    st_q  <= RX_SHIFT;
                end else if (st_q == RX_SHIFT) begin
                    sh_q <= {sh_q[WORD_W-2:0], din};
                    if (cnt_q == LAST_BIT) begin
                        vld_q <= 1'b1;
                        cnt_q <= '0;
                        st_q  <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign word_vld = vld_q;
    assign word     = ctl_word_t'(sh_q);
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           word_vld,
    input  ctl_word_t                      word,
    output logic [NUM_REGS-1:0][VAL_W-1:0] regs,
    output logic                           wr_stb
);
    logic hit;
    assign hit = word_vld && word_hits(word, NUM_REGS);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (hit && (int'(word.addr) == i))
                regs[i] <= word.value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_stb <= 1'b0;
        else     wr_stb <= hit;
    end
endmodule

// File: rtl/ctl_frame_echo.sv
module ctl_frame_echo (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic frame_in,
    input  logic mode_in,
    output logic echo,
    output logic echo_oe
);
    logic fr_q;

    always_ff @(posedge clk) begin
        if (rst)         fr_q <= 1'b0;
        else if (smp_en) fr_q <= frame_in;
    end

    assign echo_oe = mode_in;
    assign echo    = fr_q & mode_in;
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int PWR_BASE = 14,
    parameter int PWR_N    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_in,
    input  logic                      frame_in,
    input  logic                      data_in,
    output logic                      bit_clk,
    output logic                      frame_out,
    output logic                      frame_oe,
    output logic                      wr_stb,
    output logic [NUM_REGS*VAL_W-1:0] regs_flat,
    output logic [PWR_N-1:0]          sect_en
);
    logic                           smp_en;
    logic                           word_vld;
    ctl_word_t                      word;
    logic [NUM_REGS-1:0][VAL_W-1:0] regs;

    ctl_bitclk u_bclk (
        .clk     (clk),
        .rst     (rst),
        .bit_clk (bit_clk),
        .smp_en  (smp_en)
    );

    ctl_deframer u_defr (
        .clk      (clk),
        .rst      (rst),
        .smp_en   (smp_en),
        .start_ok (frame_in & mode_in),
        .din      (data_in),
        .word_vld (word_vld),
        .word     (word)
    );

    ctl_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .regs     (regs),
        .wr_stb   (wr_stb)
    );

    ctl_frame_echo u_echo (
        .clk      (clk),
        .rst      (rst),
        .smp_en   (smp_en),
        .frame_in (frame_in),
        .mode_in  (mode_in),
        .echo     (frame_out),
        .echo_oe  (frame_oe)
    );

    assign regs_flat = regs;

    // control bit n lives in register n / VAL_W, bit n % VAL_W
    for (genvar k = 0; k < PWR_N; k++) begin : g_pwr
        localparam int CB = PWR_BASE + k;
        assign sect_en[k] = regs[CB / VAL_W][CB % VAL_W];
    end
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
    parameter int FLAT_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_clk,
    input logic              frame_out,
    input logic              frame_oe,
    input logic              wr_stb,
    input logic [FLAT_W-1:0] regs_flat
);
    AST_BITCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bit_clk != $past(bit_clk))); // R1

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R4

    AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !bit_clk); // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wr_stb) |-> $stable(regs_flat)); // R4

    AST_ECHO_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame_oe && $past(frame_oe) && (frame_out != $past(frame_out))) |-> bit_clk); // R8

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_stb && (regs_flat == '0) && !frame_out)); // R10
endmodule

bind ctl_serial_port ctl_port_chk #(.FLAT_W(NUM_REGS*ctl_port_pkg::VAL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_clk   (bit_clk),
    .frame_out (frame_out),
    .frame_oe  (frame_oe),
    .wr_stb    (wr_stb),
    .regs_flat (regs_flat)
);

// File: tb/tb_ctl_serial_port.sv
`timescale 1ns/1ps
module tb_ctl_serial_port;
    localparam int NR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_in = 1'b1;
    logic frame_in = 1'b0;
    logic data_in = 1'b0;
    logic bit_clk, frame_out, frame_oe, wr_stb;
    logic [NR*10-1:0] regs_flat;
    logic [3:0] sect_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  stb_cnt = 0;
    bit  done = 0;
    logic [9:0] exp_regs [NR];

    always #2 clk = ~clk;

    ctl_serial_port dut (
        .clk(clk), .rst(rst), .mode_in(mode_in), .frame_in(frame_in),
        .data_in(data_in), .bit_clk(bit_clk), .frame_out(frame_out),
        .frame_oe(frame_oe), .wr_stb(wr_stb), .regs_flat(regs_flat),
        .sect_en(sect_en)
    );

    always @(negedge clk) if (!rst && wr_stb === 1'b1) stb_cnt++;

    function automatic logic [15:0] mkword(logic [9:0] v, logic [3:0] a, logic [1:0] s);
        return {v, a, s};
    endfunction

    function automatic bit hits(logic [15:0] w);
        return (w[1:0] == 2'b00) && (int'(w[5:2]) < NR);
    endfunction

    function automatic logic [NR*10-1:0] exp_flat();
        logic [NR*10-1:0] f;
        for (int i = 0; i < NR; i++) f[i*10 +: 10] = exp_regs[i];
        return f;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic check_state(string req);
        logic [NR*10-1:0] ef;
        ef = exp_flat();
        check(regs_flat === ef, req, 64'(regs_flat), 64'(ef));
        check(sect_en === ef[17:14], "R9", 64'(sect_en), 64'(ef[17:14]));
    endtask

    task automatic send_bit(logic f, logic d);
        while (bit_clk !== 1'b0) @(negedge clk);
        frame_in = f;
        data_in  = d;
        @(negedge clk);
        frame_in = 1'b0;
    endtask

    // sends nb bits of w starting at bit 15, frame on the first
    task automatic send_part(logic [15:0] w, int nb, bit with_frame);
        for (int i = 0; i < nb; i++) begin
            send_bit(with_frame && (i == 0), w[15-i]);
            if (i < 2 && with_frame) begin
                if (mode_in) begin
                    check(frame_oe === 1'b1, "R8 oe", 64'(frame_oe), 64'd1);
                    check(frame_out === (i == 0), "R8 echo", 64'(frame_out), 64'(i == 0));
                end else begin
                    check(frame_oe === 1'b0 && frame_out === 1'b0, "R8 off",
                          64'({frame_oe, frame_out}), 64'd0);
                end
            end
        end
    endtask

    task automatic do_word(logic [15:0] w, string req);
        bit e;
        send_part(w, 16, 1'b1);
        check(wr_stb === 1'b0, "R4 early", 64'(wr_stb), 64'd0);
        @(negedge clk);
        e = mode_in && hits(w);
        if (e) exp_regs[w[5:2]] = w[15:6];
        check(wr_stb === e, req, 64'(wr_stb), 64'(e));
        check_state(req);
        @(negedge clk);
        check(wr_stb === 1'b0, "R4 pulse", 64'(wr_stb), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        logic prev;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) exp_regs[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state, R1 low in reset
        check(bit_clk === 1'b0, "R1 reset", 64'(bit_clk), 64'd0);
        check(wr_stb === 1'b0 && frame_out === 1'b0, "R10", 64'({wr_stb, frame_out}), 64'd0);
        check_state("R10");
        rst = 1'b0;
        @(negedge clk);
        prev = bit_clk;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(bit_clk === ~prev, "R1 toggle", 64'(bit_clk), 64'(~prev));
            prev = bit_clk;
        end

        // R2 R3 field order
        do_word(mkword(10'h2A5, 4'd2, 2'b00), "R3 order");
        do_word(mkword(10'h15A, 4'd0, 2'b00), "R2 first bit");
        do_word(mkword(10'h3FF, 4'd3, 2'b00), "R4 write");
        // R9 power enables: reg1 bits 4..7 = 1010
        do_word(mkword(10'h0A0, 4'd1, 2'b00), "R9 write");
        check(sect_en === 4'b1010, "R9 map", 64'(sect_en), 64'hA);
        // R5 unused combinations
        do_word(mkword(10'h111, 4'd7, 2'b00), "R5 addr");
        do_word(mkword(10'h222, 4'd1, 2'b10), "R5 sel");
        do_word(mkword(10'h333, 4'd0, 2'b11), "R5 sel");

        // R6 abort: 9 bits of one word then a full new word
        c0 = stb_cnt;
        send_part(mkword(10'h0F0, 4'd3, 2'b00), 9, 1'b1);
        do_word(mkword(10'h00F, 4'd2, 2'b00), "R6 restart");
        check(stb_cnt == c0 + 1, "R6 count", 64'(stb_cnt - c0), 64'd1);
        check(exp_regs[3] === regs_flat[39:30], "R6 no partial", 64'(regs_flat[39:30]), 64'(exp_regs[3]));

        // R7 trailing bits with no frame
        c0 = stb_cnt;
        send_part(mkword(10'h1C3, 4'd0, 2'b00), 16, 1'b0);
        repeat (4) @(negedge clk);
        check(stb_cnt == c0, "R7 strobe", 64'(stb_cnt - c0), 64'd0);
        check_state("R7");

        // R8 mode low: frames ignored
        mode_in = 1'b0;
        c0 = stb_cnt;
        do_word(mkword(10'h2C2, 4'd1, 2'b00), "R8 ignore");
        check(stb_cnt == c0, "R8 strobe", 64'(stb_cnt - c0), 64'd0);
        mode_in = 1'b1;
        do_word(mkword(10'h2C2, 4'd1, 2'b00), "R8 back on");

        // random words
        for (int n = 0; n < 40; n++) begin
            logic [3:0] a;
            logic [1:0] s;
            a = 4'($urandom % 6);
            s = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            do_word(mkword(10'($urandom), a, s), "R4 random");
            repeat ($urandom % 5) @(negedge clk);
        end

        // R10 mid-run reset
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) exp_regs[i] = '0;
        check_state("R10 clear");
        check(wr_stb === 1'b0, "R10 stb", 64'(wr_stb), 64'd0);
        do_word(mkword(10'h0F0, 4'd1, 2'b00), "R10 after");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule